// File: doc/BRIEF.md
# Data Address Generator with Circular Buffering

This block forms the 16-bit address for each data-memory access of a signal-processing core. An access takes its address from one of four pointer registers, or, in direct mode, from the upper bits of a base register joined with a short offset carried by the instruction. A pointer access may step its pointer after use by a fixed amount or by one of two signed user increments. When circular mode is requested, the step wraps inside a buffer bounded by a begin and an end register, at no extra cycle cost.

The final address is also decoded into one-hot select lines. The lowest 16 Kwords form an internal window split into 1 Kword slots, served by six on-chip RAM banks. The upper 48 Kwords form three external segments. The RAM, the instruction decoder and any multi-access sequencing sit outside this block. The configuration registers are loaded through a simple write port driven by that decoder.

Top module: `data_agen`

## Requirements
- R1: An active-low synchronous reset clears all four pointers, both increments, the begin and end bounds and the base register to zero.
- R2: A pointer access (`acc_en`=1, `acc_direct`=0) drives `addr` with the selected pointer's value before modification. The modified value is written back on the same rising edge.
- R3: Step code on `step_sel`: 0 leaves the pointer unchanged, 1 adds 1, 2 subtracts 1, 3 adds 2, and 6 or 7 leave it unchanged. All arithmetic wraps modulo 2^16.
- R4: Step code 4 adds user increment A and code 5 adds user increment B. Both are treated as signed 16-bit values.
- R5: With `circ_en`=1, a pointer equal to the end bound that takes a positive step (+1, +2 or a positive user increment) is reloaded with the begin bound.
- R6: With `circ_en`=1, a pointer equal to the begin bound that takes a negative step (-1 or a negative user increment) is reloaded with the end bound.
- R7: In direct mode (`acc_direct`=1), `addr` = {base[15:5], `dir_ofs`[4:0]}, and no pointer changes.
- R8: An address with bits [15:14]=0 lies in the internal window. Bits [13:10] give a slot number from 0 to 15, and `bank_en[slot mod 6]` is raised.
- R9: An address with bits [15:14] equal to 1, 2 or 3 raises `ext_en[0]`, `ext_en[1]` or `ext_en[2]` respectively.
- R10: While `acc_en`=1, exactly one bit of {`ext_en`,`bank_en`} is high. While `acc_en`=0, all of them are low.
- R11: The write port selects a register through `wr_sel`: 0 to 3 select pointers 0 to 3, 4 selects increment A, 5 increment B, 6 the begin bound, 7 the end bound and 8 the base. A write to a pointer in the same cycle as that pointer's post-modification takes priority.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select for a write |
| wr_data | input | 16 | Write data |
| acc_en | input | 1 | Access strobe |
| acc_direct | input | 1 | 1: direct mode, 0: pointer mode |
| ptr_sel | input | 2 | Pointer used by a pointer access |
| step_sel | input | 3 | Post-modification code |
| circ_en | input | 1 | Circular wrap enable |
| dir_ofs | input | 5 | Instruction offset for direct mode |
| addr | output | 16 | Access address (combinational) |
| bank_en | output | 6 | On-chip bank selects |
| ext_en | output | 3 | External segment selects |

## Verification
The hardest situations to reach are the two circular reloads. Each needs a pointer sitting exactly on a bound while a step of the matching sign is applied, and a user increment can cause the reload as well as a fixed step. The stimulus loads the begin and end bounds around a three-word buffer, then walks a pointer upward onto the end bound and downward onto the begin bound with both fixed and user steps. A hold access after each step exposes the reloaded value on `addr`. A write and a post-modification aimed at the same pointer in one cycle are also driven together to show which one wins.

// File: rtl/agen_pkg.sv
// Package: shared step codes for the data address generator.
// Assumes a 3-bit step code; unlisted codes mean "no change".
package agen_pkg;

    localparam int STEP_W = 3;

    localparam logic [STEP_W-1:0] STEP_HOLD = 3'd0;
    localparam logic [STEP_W-1:0] STEP_INC1 = 3'd1;
    localparam logic [STEP_W-1:0] STEP_DEC1 = 3'd2;
    localparam logic [STEP_W-1:0] STEP_INC2 = 3'd3;
    localparam logic [STEP_W-1:0] STEP_USRA = 3'd4;
    localparam logic [STEP_W-1:0] STEP_USRB = 3'd5;

endpackage

// File: rtl/agen_regfile.sv
// Module: configuration and pointer storage.
// Holds NPTR pointers plus two increments, the ring bounds and the base.
// Register codes: 0..NPTR-1 pointers, then inc A, inc B, begin, end, base.
// Assumes a config write to a pointer beats a same-cycle post-modification.
module agen_regfile #(
    parameter int AW   = 16,
    parameter int NPTR = 4,
    parameter int SELW = 4,
    parameter int PW   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [SELW-1:0]          wr_sel,
    input  logic [AW-1:0]            wr_data,
    input  logic                     upd_en,
    input  logic [PW-1:0]            upd_idx,
    input  logic [AW-1:0]            upd_val,
    output logic [NPTR-1:0][AW-1:0]  ptr_q,
    output logic [AW-1:0]            inc_a_q,
    output logic [AW-1:0]            inc_b_q,
    output logic [AW-1:0]            ring_lo_q,
    output logic [AW-1:0]            ring_hi_q,
    output logic [AW-1:0]            base_q
);

    localparam logic [SELW-1:0] SEL_INCA = SELW'(NPTR);
    localparam logic [SELW-1:0] SEL_INCB = SELW'(NPTR + 1);
    localparam logic [SELW-1:0] SEL_LO   = SELW'(NPTR + 2);
    localparam logic [SELW-1:0] SEL_HI   = SELW'(NPTR + 3);
    localparam logic [SELW-1:0] SEL_BASE = SELW'(NPTR + 4);

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        // Pointer g: reset, config write, or post-modification write-back.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ptr_q[g] <= '0;
            end else if (wr_en && (wr_sel == SELW'(g))) begin
                ptr_q[g] <= wr_data;
            end else if (upd_en && (upd_idx == PW'(g))) begin
                ptr_q[g] <= upd_val;
            end
        end
    end

    // Non-pointer registers: loaded only through the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inc_a_q   <= '0;
            inc_b_q   <= '0;
            ring_lo_q <= '0;
            ring_hi_q <= '0;
            base_q    <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_INCA: inc_a_q   <= wr_data;
                SEL_INCB: inc_b_q   <= wr_data;
                SEL_LO:   ring_lo_q <= wr_data;
                SEL_HI:   ring_hi_q <= wr_data;
                SEL_BASE: base_q    <= wr_data;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/agen_postmod.sv
// Module: post-modification arithmetic for one pointer value.
// Picks a step, adds it modulo 2^AW, and applies the circular reload
// at either bound depending on the sign of the step. Purely combinational.
module agen_postmod
    import agen_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0]     cur,
    input  logic [STEP_W-1:0] step_sel,
    input  logic [AW-1:0]     inc_a,
    input  logic [AW-1:0]     inc_b,
    input  logic              circ_en,
    input  logic [AW-1:0]     ring_lo,
    input  logic [AW-1:0]     ring_hi,
    output logic [AW-1:0]     nxt
);

    logic [AW-1:0] delta;
    logic          goes_up;
    logic          goes_dn;

    // Step value selection from the code.
    always_comb begin
        case (step_sel)
            STEP_INC1: delta = AW'(1);
            STEP_DEC1: delta = '1;
            STEP_INC2: delta = AW'(2);
            STEP_USRA: delta = inc_a;
            STEP_USRB: delta = inc_b;
            default:   delta = '0;
        endcase
    end

    // Sign of the step: a zero step moves in neither direction.
    always_comb begin
        goes_dn = delta[AW-1];
        goes_up = !delta[AW-1] && (delta != '0);
    end

    // Sum with circular reload at the bound being crossed.
    always_comb begin
        if (circ_en && goes_up && (cur == ring_hi)) begin
            nxt = ring_lo;
        end else if (circ_en && goes_dn && (cur == ring_lo)) begin
            nxt = ring_hi;
        end else begin
            nxt = cur + delta;
        end
    end

endmodule

// File: rtl/agen_bankdec.sv
// Module: one-hot select decode of a data address.
// The lowest 2^WIN_AW words are an internal window of 2^BANK_AW-word
// slots mirrored onto NBANK banks (slot mod NBANK). Each remaining
// window-sized region above it is one external segment.
module agen_bankdec #(
    parameter int AW      = 16,
    parameter int WIN_AW  = 14,
    parameter int BANK_AW = 10,
    parameter int NBANK   = 6,
    parameter int NEXT    = 3
) (
    input  logic              en,
    input  logic [AW-1:0]     addr,
    output logic [NBANK-1:0]  bank_en,
    output logic [NEXT-1:0]   ext_en
);

    localparam int RW = AW - WIN_AW;
    localparam int SW = WIN_AW - BANK_AW;

    logic [RW-1:0] region;
    logic [SW-1:0] slot;
    logic [SW-1:0] bank_idx;
    logic          in_win;

    // Split the address into region and slot, fold slot onto banks.
    always_comb begin
        region   = addr[AW-1:WIN_AW];
        slot     = addr[WIN_AW-1:BANK_AW];
        bank_idx = slot % SW'(NBANK);
        in_win   = (region == '0);
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign bank_en[b] = en && in_win && (bank_idx == SW'(b));
    end

    for (genvar e = 0; e < NEXT; e++) begin : g_ext
        assign ext_en[e] = en && (region == RW'(e + 1));
    end

endmodule

// File: rtl/data_agen.sv
// Module: data address generator top.
// Forms the access address from a pointer (pre-modification value) or
// from base prefix plus instruction offset, writes the stepped pointer
// back on the clock edge, and decodes the address into select lines.
// Assumes addr is consumed combinationally in the access cycle.
module data_agen
    import agen_pkg::*;
#(
    parameter int AW      = 16,
    parameter int NPTR    = 4,
    parameter int OFS_W   = 5,
    parameter int NBANK   = 6,
    parameter int BANK_AW = 10,
    parameter int WIN_AW  = 14,
    localparam int PW     = $clog2(NPTR),
    localparam int SELW   = $clog2(NPTR + 5),
    localparam int NEXT   = (1 << (AW - WIN_AW)) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SELW-1:0]   wr_sel,
    input  logic [AW-1:0]     wr_data,
    input  logic              acc_en,
    input  logic              acc_direct,
    input  logic [PW-1:0]     ptr_sel,
    input  logic [STEP_W-1:0] step_sel,
    input  logic              circ_en,
    input  logic [OFS_W-1:0]  dir_ofs,
    output logic [AW-1:0]     addr,
    output logic [NBANK-1:0]  bank_en,
    output logic [NEXT-1:0]   ext_en
);

    logic [NPTR-1:0][AW-1:0] ptr_q;
    logic [AW-1:0] inc_a_q, inc_b_q, ring_lo_q, ring_hi_q, base_q;
    logic [AW-1:0] cur_ptr;
    logic [AW-1:0] nxt_ptr;
    logic          upd_en;

    agen_regfile #(
        .AW(AW), .NPTR(NPTR), .SELW(SELW), .PW(PW)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .upd_en    (upd_en),
        .upd_idx   (ptr_sel),
        .upd_val   (nxt_ptr),
        .ptr_q     (ptr_q),
        .inc_a_q   (inc_a_q),
        .inc_b_q   (inc_b_q),
        .ring_lo_q (ring_lo_q),
        .ring_hi_q (ring_hi_q),
        .base_q    (base_q)
    );

    // Source selection and write-back enable for the current access.
    always_comb begin
        cur_ptr = ptr_q[ptr_sel];
        upd_en  = acc_en && !acc_direct;
        if (acc_direct) begin
            addr = {base_q[AW-1:OFS_W], dir_ofs};
        end else begin
            addr = cur_ptr;
        end
    end

    agen_postmod #(.AW(AW)) u_step (
        .cur      (cur_ptr),
        .step_sel (step_sel),
        .inc_a    (inc_a_q),
        .inc_b    (inc_b_q),
        .circ_en  (circ_en),
        .ring_lo  (ring_lo_q),
        .ring_hi  (ring_hi_q),
        .nxt      (nxt_ptr)
    );

    agen_bankdec #(
        .AW(AW), .WIN_AW(WIN_AW), .BANK_AW(BANK_AW),
        .NBANK(NBANK), .NEXT(NEXT)
    ) u_dec (
        .en      (acc_en),
        .addr    (addr),
        .bank_en (bank_en),
        .ext_en  (ext_en)
    );

endmodule

// File: rtl/data_agen_chk.sv
// Checker: port-level properties of the data address generator.
module data_agen_chk #(
    parameter int AW    = 16,
    parameter int PW    = 2,
    parameter int OFS_W = 5,
    parameter int NBANK = 6,
    parameter int NEXT  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             acc_en,
    input logic             acc_direct,
    input logic [PW-1:0]    ptr_sel,
    input logic [2:0]       step_sel,
    input logic             circ_en,
    input logic [OFS_W-1:0] dir_ofs,
    input logic [AW-1:0]    addr,
    input logic [NBANK-1:0] bank_en,
    input logic [NEXT-1:0]  ext_en
);

    // R10
    one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |-> ($countones({ext_en, bank_en}) == 1));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |-> (bank_en == '0) && (ext_en == '0));

    // R9
    ext_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && (addr[AW-1:AW-2] != 2'b00)) |-> (bank_en == '0));

    // R8
    int_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && (addr[AW-1:AW-2] == 2'b00)) |-> (ext_en == '0));

    // R7
    direct_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_direct) |-> (addr[OFS_W-1:0] == dir_ofs));

    // R3
    step_plus_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_direct && (ptr_sel == $past(ptr_sel)) &&
         $past(acc_en && !acc_direct && (step_sel == 3'd1) && !circ_en && !wr_en))
        |-> (addr == $past(addr) + 16'd1));

endmodule

bind data_agen data_agen_chk #(
    .AW(AW), .PW(PW), .OFS_W(OFS_W), .NBANK(NBANK), .NEXT(NEXT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .acc_en     (acc_en),
    .acc_direct (acc_direct),
    .ptr_sel    (ptr_sel),
    .step_sel   (step_sel),
    .circ_en    (circ_en),
    .dir_ofs    (dir_ofs),
    .addr       (addr),
    .bank_en    (bank_en),
    .ext_en     (ext_en)
);

// File: tb/sim_data_agen.sv
// Bench: table-driven walk of writes and accesses, then directed reset cases.
module sim_data_agen;

    typedef struct packed {
        logic        wr;
        logic [3:0]  sel;
        logic [15:0] data;
        logic        acc;
        logic        dir;
        logic [1:0]  psel;
        logic [2:0]  step;
        logic        circ;
        logic [4:0]  ofs;
        logic [15:0] eaddr;
        logic [8:0]  een;   // {ext_en[2:0], bank_en[5:0]}
        logic [3:0]  rq;
    } vec_t;

    function automatic vec_t mk(logic wr, logic [3:0] sel, logic [15:0] data,
                                logic acc, logic dir, logic [1:0] psel,
                                logic [2:0] step, logic circ, logic [4:0] ofs,
                                logic [15:0] eaddr, logic [8:0] een, logic [3:0] rq);
        mk = '{wr, sel, data, acc, dir, psel, step, circ, ofs, eaddr, een, rq};
    endfunction

    // Write only: enables must stay low (R10).
    function automatic vec_t mkw(logic [3:0] sel, logic [15:0] data);
        mkw = mk(1'b1, sel, data, 1'b0, 1'b0, 2'd0, 3'd0, 1'b0, 5'd0, 16'h0, 9'h000, 4'd10);
    endfunction

    function automatic vec_t mka(logic dir, logic [1:0] psel, logic [2:0] step,
                                 logic circ, logic [4:0] ofs, logic [15:0] eaddr,
                                 logic [8:0] een, logic [3:0] rq);
        mka = mk(1'b0, 4'd0, 16'h0, 1'b1, dir, psel, step, circ, ofs, eaddr, een, rq);
    endfunction

    localparam int NV = 50;
    localparam vec_t VT [NV] = '{
        mkw(4'd0, 16'h0010),
        mka(0, 2'd0, 3'd1, 0, 5'd0, 16'h0010, 9'h001, 4'd2),   // R2 pre-mod address
        mka(0, 2'd0, 3'd1, 0, 5'd0, 16'h0011, 9'h001, 4'd3),   // R3 +1
        mka(0, 2'd0, 3'd3, 0, 5'd0, 16'h0012, 9'h001, 4'd3),   // R3 +2
        mka(0, 2'd0, 3'd2, 0, 5'd0, 16'h0014, 9'h001, 4'd3),   // R3 -1
        mka(0, 2'd0, 3'd0, 0, 5'd0, 16'h0013, 9'h001, 4'd3),   // R3 hold
        mka(0, 2'd0, 3'd6, 0, 5'd0, 16'h0013, 9'h001, 4'd3),   // R3 code 6 holds
        mkw(4'd4, 16'h0400),                                   // R11 inc A
        mka(0, 2'd0, 3'd4, 0, 5'd0, 16'h0013, 9'h001, 4'd4),   // R4
        mka(0, 2'd0, 3'd0, 0, 5'd0, 16'h0413, 9'h002, 4'd4),   // R4 bank1
        mkw(4'd5, 16'hFC00),                                   // inc B = -1024
        mka(0, 2'd0, 3'd5, 0, 5'd0, 16'h0413, 9'h002, 4'd4),
        mka(0, 2'd0, 3'd0, 0, 5'd0, 16'h0013, 9'h001, 4'd4),   // R4 signed
        mkw(4'd1, 16'h0800),
        mkw(4'd6, 16'h0800),                                   // begin
        mkw(4'd7, 16'h0802),                                   // end
        mka(0, 2'd1, 3'd1, 1, 5'd0, 16'h0800, 9'h004, 4'd5),
        mka(0, 2'd1, 3'd1, 1, 5'd0, 16'h0801, 9'h004, 4'd5),
        mka(0, 2'd1, 3'd1, 1, 5'd0, 16'h0802, 9'h004, 4'd5),   // at end
        mka(0, 2'd1, 3'd0, 0, 5'd0, 16'h0800, 9'h004, 4'd5),   // R5 reloaded begin
        mka(0, 2'd1, 3'd2, 1, 5'd0, 16'h0800, 9'h004, 4'd6),   // at begin, -1
        mka(0, 2'd1, 3'd0, 0, 5'd0, 16'h0802, 9'h004, 4'd6),   // R6 reloaded end
        mka(0, 2'd1, 3'd1, 0, 5'd0, 16'h0802, 9'h004, 4'd5),   // circ off
        mka(0, 2'd1, 3'd0, 0, 5'd0, 16'h0803, 9'h004, 4'd5),   // R5 no wrap
        mkw(4'd2, 16'h1800),
        mka(0, 2'd2, 3'd0, 0, 5'd0, 16'h1800, 9'h001, 4'd8),   // R8 slot 6 -> bank 0
        mkw(4'd2, 16'h3C00),
        mka(0, 2'd2, 3'd1, 0, 5'd0, 16'h3C00, 9'h008, 4'd8),   // R8 slot 15 -> bank 3
        mka(0, 2'd2, 3'd0, 0, 5'd0, 16'h3C01, 9'h008, 4'd8),
        mkw(4'd3, 16'h4000),
        mka(0, 2'd3, 3'd5, 0, 5'd0, 16'h4000, 9'h040, 4'd9),   // R9 ext 0
        mka(0, 2'd3, 3'd0, 0, 5'd0, 16'h3C00, 9'h008, 4'd8),
        mkw(4'd3, 16'hBFFF),
        mka(0, 2'd3, 3'd1, 0, 5'd0, 16'hBFFF, 9'h080, 4'd9),   // R9 ext 1
        mka(0, 2'd3, 3'd3, 0, 5'd0, 16'hC000, 9'h100, 4'd9),   // R9 ext 2
        mka(0, 2'd3, 3'd0, 0, 5'd0, 16'hC002, 9'h100, 4'd9),
        mkw(4'd3, 16'hFFFF),
        mka(0, 2'd3, 3'd1, 0, 5'd0, 16'hFFFF, 9'h100, 4'd9),
        mka(0, 2'd3, 3'd0, 0, 5'd0, 16'h0000, 9'h001, 4'd3),   // R3 modulo wrap
        mkw(4'd8, 16'h4A3F),                                   // base
        mka(1, 2'd0, 3'd1, 0, 5'h15, 16'h4A35, 9'h040, 4'd7),  // R7 direct
        mka(0, 2'd0, 3'd0, 0, 5'd0, 16'h0013, 9'h001, 4'd7),   // R7 p0 untouched
        mk(1'b1, 4'd0, 16'h0100, 1'b1, 1'b0, 2'd0, 3'd1, 1'b0, 5'd0,
           16'h0013, 9'h001, 4'd11),                           // R11 collision
        mka(0, 2'd0, 3'd0, 0, 5'd0, 16'h0100, 9'h001, 4'd11),  // R11 write wins
        mkw(4'd4, 16'h0001),
        mkw(4'd1, 16'h0802),
        mka(0, 2'd1, 3'd4, 1, 5'd0, 16'h0802, 9'h004, 4'd5),   // R5 user step
        mka(0, 2'd1, 3'd0, 0, 5'd0, 16'h0800, 9'h004, 4'd5),
        mka(0, 2'd1, 3'd5, 1, 5'd0, 16'h0800, 9'h004, 4'd6),   // R6 user step
        mka(0, 2'd1, 3'd0, 0, 5'd0, 16'h0802, 9'h004, 4'd6)
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [3:0]  wr_sel;
    logic [15:0] wr_data;
    logic        acc_en;
    logic        acc_direct;
    logic [1:0]  ptr_sel;
    logic [2:0]  step_sel;
    logic        circ_en;
    logic [4:0]  dir_ofs;
    logic [15:0] addr;
    logic [5:0]  bank_en;
    logic [2:0]  ext_en;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    data_agen u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .acc_en(acc_en), .acc_direct(acc_direct),
        .ptr_sel(ptr_sel), .step_sel(step_sel), .circ_en(circ_en),
        .dir_ofs(dir_ofs), .addr(addr), .bank_en(bank_en), .ext_en(ext_en)
    );

    task automatic drive(input vec_t v);
        wr_en = v.wr; wr_sel = v.sel; wr_data = v.data;
        acc_en = v.acc; acc_direct = v.dir; ptr_sel = v.psel;
        step_sel = v.step; circ_en = v.circ; dir_ofs = v.ofs;
    endtask

    task automatic check(input string tag, input logic [15:0] a_exp,
                         input logic [8:0] e_exp, input bit chk_addr);
        checks++;
        if ({ext_en, bank_en} !== e_exp) begin
            errors++;
            $display("FAIL %s enables=%h expected %h", tag, {ext_en, bank_en}, e_exp);
        end
        if (chk_addr) begin
            checks++;
            if (addr !== a_exp) begin
                errors++;
                $display("FAIL %s addr=%h expected %h", tag, addr, a_exp);
            end
        end
    endtask

    // One pointer-mode access cycle, checked mid-cycle.
    task automatic access(input logic [1:0] p, input logic [2:0] s, input logic c,
                          input logic [15:0] a_exp, input logic [8:0] e_exp,
                          input string tag);
        @(negedge clk);
        drive(mka(1'b0, p, s, c, 5'd0, 16'h0, 9'h0, 4'd0));
        #5 check(tag, a_exp, e_exp, 1'b1);
    endtask

    initial begin
        drive(mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #5 check("R10 idle after reset", 16'h0, 9'h000, 1'b0);
        rst_n = 1'b1;
        // R1: every pointer and the base read zero.
        for (int p = 0; p < 4; p++) begin
            access(2'(p), 3'd0, 1'b0, 16'h0000, 9'h001, "R1 pointer reset");
        end
        @(negedge clk);
        drive(mka(1'b1, 2'd0, 3'd0, 1'b0, 5'h07, 16'h0, 9'h0, 4'd0));
        #5 check("R1 base reset", 16'h0007, 9'h001, 1'b1);

        // Table walk, one vector per cycle.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VT[i]);
            #5 check($sformatf("R%0d vec %0d", VT[i].rq, i),
                     VT[i].eaddr, VT[i].een, VT[i].acc);
        end

        // R1: reset in mid-run clears loaded state.
        @(negedge clk);
        drive(mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        access(2'd1, 3'd1, 1'b1, 16'h0000, 9'h001, "R1 p1 cleared");
        access(2'd1, 3'd0, 1'b0, 16'h0000, 9'h001, "R1 R5 bounds cleared, wrap to 0");
        access(2'd2, 3'd4, 1'b0, 16'h0000, 9'h001, "R1 inc A cleared");
        access(2'd2, 3'd0, 1'b0, 16'h0000, 9'h001, "R1 R4 zero step");
        access(2'd3, 3'd5, 1'b0, 16'h0000, 9'h001, "R1 inc B cleared");
        access(2'd3, 3'd7, 1'b0, 16'h0000, 9'h001, "R1 R3 code 7 holds");
        @(negedge clk);
        drive(mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        #5 check("R10 idle", 16'h0, 9'h000, 1'b0);
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired: done=0 expected 1");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule